// File: doc/BRIEF.md
# Double-Buffered Serial Slave Transceiver

This block is a single-lane synchronous serial slave. An external master supplies a serial clock, an active-low chip select and a data input line. The block returns data on its output line. Characters are 1 to 16 bits long. One shift register is shared by both directions: each clock shifts one bit out and one bit in. A transmit buffer and a receive buffer sit on either side of the shift register. Software can therefore queue the next outgoing character and collect the last incoming one while a transfer is running.

Software reaches the block through a small register port. It uses this port to enable the module, set the character length, write outgoing data, read incoming data, and inspect or clear four event flags. Each flag clears in its own way. The transmit-empty flag clears on a write to the transmit register. The receive-full flag clears on a read of the receive register. The end-of-transfer and overrun flags clear when software writes 1 to them. A per-flag enable mask combines the flags into one interrupt request.

A slave transfer ends in two steps. Software waits for the end-of-transfer flag, then clears the enable bit. Clearing the enable bit stops the channel and returns its state to idle.

Top module: `serial_slave_dbuf`

## Requirements
- R1: After reset, all four flags, the busy bit, the interrupt request and the serial output are 0.
- R2: The character length is the control field at bits [7:4] plus one, so field 0 gives 1 bit and field 15 gives 16 bits. Bits arrive most significant first and are stored right-aligned in the receive register, with the unused upper bits 0. The enable bit is control bit 0.
- R3: Each character is sent most significant bit first. The sent bits are the low bits of the transmit data, up to the programmed length. The master samples them on the rising edge of the serial clock.
- R4: Flag bit 0 (transmit empty) sets when the buffered transmit word moves into the shift register. A write to the transmit register (address 1) clears it. Writing 1 to it in the flag register has no effect.
- R5: Flag bit 1 (receive full) sets when a complete character is copied into the receive buffer. A read of the receive register (address 2) clears it.
- R6: Flag bit 2 (end of transfer) sets when a character loaded from the transmit buffer finishes while flag bit 0 is 1. Writing 1 to bit 2 of the flag register (address 3) clears it.
- R7: When a character completes while flag bit 1 is still set, flag bit 3 (overrun) sets. The new character is discarded and the old one is kept. Writing 1 to bit 3 clears the overrun flag.
- R8: If the transmit buffer is empty when a character starts, the block sends zeros for that character and does not raise end of transfer.
- R9: The interrupt request is high exactly when some flag is 1 and its enable bit is also 1. The enable register is at address 4, and its bits [3:0] follow the same order as the flag bits.
- R10: Flag register bit 4 (busy) reads 1 while the module is enabled and chip select is asserted.
- R11: Clearing the enable bit clears all flags, both buffers, the shift register and the bit counter. Serial activity is ignored while the module is disabled.
- R12: If chip select is released part-way through a character, the partial bits are dropped and no flag changes. The next selection starts a fresh character.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least four times the serial clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | 3 | Register address (0 control, 1 transmit, 2 receive, 3 flags, 4 interrupt enable) |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe (side effects only; data is always driven) |
| regWdata | input | 16 | Register write data |
| regRdata | output | 16 | Register read data for regAddr |
| irq | output | 1 | Combined interrupt request |
| sclk | input | 1 | Serial clock from the master, idle low |
| csN | input | 1 | Active-low chip select from the master |
| mosi | input | 1 | Serial data from the master |
| miso | output | 1 | Serial data to the master, 0 when not selected |

## Verification
Some rules are checked by assertions on every cycle. A transmit-register write always leaves the transmit-empty flag low. A receive read without a coincident capture always clears receive-full. End of transfer can only rise after the transmit-empty flag was already set. The receive buffer holds still when an overrun is raised. A disabled module shows no flags and no request. Busy and the interrupt request stay consistent with their enables. The bench scenarios cover what a single-cycle property cannot reach: the exact bit order on the serial output at lengths 1, 8 and 16, back-to-back characters under one selection with a reload between them, zero-fill for an empty buffer, the order in which each flag clears, an aborted partial character, and the full wipe on disable.

// File: rtl/ssd_pkg.sv
package ssd_pkg;

  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] ADDR_CTRL  = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_TX    = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_RX    = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_FLAGS = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_IEN   = 3'd4;

  localparam int NUM_FLAGS = 4;
  localparam int FLG_TBE   = 0;
  localparam int FLG_RBF   = 1;
  localparam int FLG_TEND  = 2;
  localparam int FLG_OVR   = 3;
  localparam int BUSY_BIT  = 4;
  localparam int LEN_LSB   = 4;

  // strobes from control to datapath
  typedef struct packed {
    logic clrAll;     // module disabled: wipe serial state
    logic startChar;  // load shift register from transmit buffer
    logic shiftBit;   // one serial clock rising edge
    logic captureRx;  // copy finished character to receive buffer
    logic txWrite;    // software writes transmit buffer
  } dpCtl_t;

endpackage

// File: rtl/ssd_datapath.sv
module ssd_datapath
  import ssd_pkg::*;
#(
  parameter int DATA_W = 16,
  localparam int LEN_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic [DATA_W-1:0] wdata,
  input  logic [LEN_W-1:0]  lenM1,
  input  logic              mosiBit,
  output logic              lastBit,
  output logic              txFull,
  output logic              hadData,
  output logic [DATA_W-1:0] rxBuf,
  output logic              misoBit
);

  logic [DATA_W-1:0] txBuf;
  logic [DATA_W-1:0] shiftReg;
  logic [DATA_W-1:0] shifted;
  logic [DATA_W-1:0] lenMask;
  logic [LEN_W-1:0]  bitCnt;

  // mask of the bits that belong to the programmed character
  for (genvar i = 0; i < DATA_W; i++) begin : g_mask
    assign lenMask[i] = (LEN_W'(i) <= lenM1);
  end

  assign shifted = {shiftReg[DATA_W-2:0], mosiBit};
  assign lastBit = (bitCnt == lenM1);
  assign misoBit = shiftReg[lenM1];

  // transmit buffer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txBuf  <= '0;
      txFull <= 1'b0;
    end else if (ctl.clrAll) begin
      txBuf  <= '0;
      txFull <= 1'b0;
    end else if (ctl.txWrite) begin
      txBuf  <= wdata;
      txFull <= 1'b1;
    end else if (ctl.startChar) begin
      txFull <= 1'b0;
    end
  end

  // shared shift register and bit counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      bitCnt   <= '0;
      hadData  <= 1'b0;
    end else if (ctl.clrAll) begin
      shiftReg <= '0;
      bitCnt   <= '0;
      hadData  <= 1'b0;
    end else if (ctl.startChar) begin
      shiftReg <= txFull ? txBuf : '0;
      bitCnt   <= '0;
      hadData  <= txFull;
    end else if (ctl.shiftBit) begin
      shiftReg <= shifted;
      bitCnt   <= bitCnt + 1'b1;
    end
  end

  // receive buffer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxBuf <= '0;
    end else if (ctl.clrAll) begin
      rxBuf <= '0;
    end else if (ctl.captureRx) begin
      rxBuf <= shifted & lenMask;
    end
  end

endmodule

// File: rtl/ssd_control.sv
module ssd_control
  import ssd_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2,
  localparam int LEN_W = $clog2(DATA_W),
  localparam int CTL_W = LEN_LSB + LEN_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic                 regWr,
  input  logic                 regRd,
  input  logic [CTL_W-1:0]     ctlWdata,
  output logic [DATA_W-1:0]    regRdata,
  output logic                 irq,
  input  logic                 sclkIn,
  input  logic                 csNIn,
  input  logic                 mosiIn,
  input  logic                 dpLastBit,
  input  logic                 dpTxFull,
  input  logic                 dpHadData,
  input  logic [DATA_W-1:0]    dpRxBuf,
  output dpCtl_t               ctl,
  output logic                 mosiBit,
  output logic [LEN_W-1:0]     lenM1,
  output logic                 csLow,
  output logic                 modEn,
  output logic [NUM_FLAGS-1:0] flags,
  output logic [NUM_FLAGS-1:0] ienReg,
  output logic                 busy
);

  logic [SYNC_STAGES-1:0] sclkSync;
  logic [SYNC_STAGES-1:0] csSync;
  logic [SYNC_STAGES-1:0] mosiSync;
  logic sclkPrev;
  logic csPrev;
  logic sclkRise;
  logic csFall;
  logic charDone;
  logic rxRead;
  logic flagWr;
  logic ctrlWr;
  logic ienWr;

  // input synchronizers and edge history
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkSync <= '0;
      csSync   <= '1;
      mosiSync <= '0;
      sclkPrev <= 1'b0;
      csPrev   <= 1'b1;
    end else begin
      sclkSync <= {sclkSync[SYNC_STAGES-2:0], sclkIn};
      csSync   <= {csSync[SYNC_STAGES-2:0], csNIn};
      mosiSync <= {mosiSync[SYNC_STAGES-2:0], mosiIn};
      sclkPrev <= sclkSync[SYNC_STAGES-1];
      csPrev   <= csSync[SYNC_STAGES-1];
    end
  end

  assign sclkRise = sclkSync[SYNC_STAGES-1] & ~sclkPrev;
  assign csFall   = csPrev & ~csSync[SYNC_STAGES-1];
  assign csLow    = ~csSync[SYNC_STAGES-1];
  assign mosiBit  = mosiSync[SYNC_STAGES-1];

  // register decode
  assign ctrlWr = regWr && (regAddr == ADDR_CTRL);
  assign ienWr  = regWr && (regAddr == ADDR_IEN);
  assign flagWr = modEn && regWr && (regAddr == ADDR_FLAGS);
  assign rxRead = modEn && regRd && (regAddr == ADDR_RX);

  // datapath strobes
  assign ctl.clrAll    = ~modEn;
  assign ctl.txWrite   = modEn && regWr && (regAddr == ADDR_TX);
  assign ctl.shiftBit  = modEn && csLow && sclkRise;
  assign charDone      = ctl.shiftBit && dpLastBit;
  assign ctl.startChar = modEn && (csFall || charDone);
  assign ctl.captureRx = charDone && !flags[FLG_RBF];

  // control and enable registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modEn  <= 1'b0;
      lenM1  <= '1;
      ienReg <= '0;
    end else begin
      if (ctrlWr) begin
        modEn <= ctlWdata[0];
        lenM1 <= ctlWdata[LEN_LSB +: LEN_W];
      end
      if (ienWr) begin
        ienReg <= ctlWdata[NUM_FLAGS-1:0];
      end
    end
  end

  // event flags, each with its own clear path
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flags <= '0;
    end else if (!modEn) begin
      flags <= '0;
    end else begin
      if (ctl.txWrite) begin
        flags[FLG_TBE] <= 1'b0;
      end else if (ctl.startChar && dpTxFull) begin
        flags[FLG_TBE] <= 1'b1;
      end

      if (ctl.captureRx) begin
        flags[FLG_RBF] <= 1'b1;
      end else if (rxRead) begin
        flags[FLG_RBF] <= 1'b0;
      end

      if (charDone && dpHadData && flags[FLG_TBE]) begin
        flags[FLG_TEND] <= 1'b1;
      end else if (flagWr && ctlWdata[FLG_TEND]) begin
        flags[FLG_TEND] <= 1'b0;
      end

      if (charDone && flags[FLG_RBF]) begin
        flags[FLG_OVR] <= 1'b1;
      end else if (flagWr && ctlWdata[FLG_OVR]) begin
        flags[FLG_OVR] <= 1'b0;
      end
    end
  end

  assign busy = modEn && csLow;
  assign irq  = |(flags & ienReg);

  // read data mux
  always_comb begin
    regRdata = '0;
    case (regAddr)
      ADDR_CTRL: begin
        regRdata[0] = modEn;
        regRdata[LEN_LSB +: LEN_W] = lenM1;
      end
      ADDR_RX:    regRdata = dpRxBuf;
      ADDR_FLAGS: begin
        regRdata[NUM_FLAGS-1:0] = flags;
        regRdata[BUSY_BIT] = busy;
      end
      ADDR_IEN:   regRdata[NUM_FLAGS-1:0] = ienReg;
      default:    regRdata = '0;
    endcase
  end

endmodule

// File: rtl/serial_slave_dbuf.sv
module serial_slave_dbuf
  import ssd_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2,
  localparam int LEN_W = $clog2(DATA_W),
  localparam int CTL_W = LEN_LSB + LEN_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        regAddr,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output logic              irq,
  input  logic              sclk,
  input  logic              csN,
  input  logic              mosi,
  output logic              miso
);

  dpCtl_t               ctl;
  logic                 mosiBit;
  logic [LEN_W-1:0]     lenM1;
  logic                 csLow;
  logic                 modEn;
  logic [NUM_FLAGS-1:0] flags;
  logic [NUM_FLAGS-1:0] ienReg;
  logic                 busy;
  logic                 dpLastBit;
  logic                 dpTxFull;
  logic                 dpHadData;
  logic [DATA_W-1:0]    dpRxBuf;
  logic                 dpMiso;

  ssd_control #(
    .DATA_W(DATA_W),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_control (
    .clk(clk),
    .rstN(rstN),
    .regAddr(regAddr),
    .regWr(regWr),
    .regRd(regRd),
    .ctlWdata(regWdata[CTL_W-1:0]),
    .regRdata(regRdata),
    .irq(irq),
    .sclkIn(sclk),
    .csNIn(csN),
    .mosiIn(mosi),
    .dpLastBit(dpLastBit),
    .dpTxFull(dpTxFull),
    .dpHadData(dpHadData),
    .dpRxBuf(dpRxBuf),
    .ctl(ctl),
    .mosiBit(mosiBit),
    .lenM1(lenM1),
    .csLow(csLow),
    .modEn(modEn),
    .flags(flags),
    .ienReg(ienReg),
    .busy(busy)
  );

  ssd_datapath #(
    .DATA_W(DATA_W)
  ) u_datapath (
    .clk(clk),
    .rstN(rstN),
    .ctl(ctl),
    .wdata(regWdata),
    .lenM1(lenM1),
    .mosiBit(mosiBit),
    .lastBit(dpLastBit),
    .txFull(dpTxFull),
    .hadData(dpHadData),
    .rxBuf(dpRxBuf),
    .misoBit(dpMiso)
  );

  assign miso = modEn && csLow && dpMiso;

endmodule

// File: rtl/ssd_checker.sv
module ssd_checker
  import ssd_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [2:0]           regAddr,
  input logic                 regRd,
  input logic                 modEn,
  input logic                 busy,
  input logic                 irq,
  input logic [NUM_FLAGS-1:0] ienReg,
  input logic [NUM_FLAGS-1:0] flags,
  input logic [DATA_W-1:0]    dpRxBuf,
  input dpCtl_t               ctl
);

  assert_txwrite_clears_tbe_R4: assert property (@(posedge clk) disable iff (!rstN)
    ctl.txWrite |=> !flags[FLG_TBE]);

  assert_rxread_clears_rbf_R5: assert property (@(posedge clk) disable iff (!rstN)
    (regRd && regAddr == ADDR_RX && !ctl.captureRx) |=> !flags[FLG_RBF]);

  assert_tend_after_tbe_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flags[FLG_TEND]) |-> $past(flags[FLG_TBE]));

  assert_overrun_keeps_rx_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flags[FLG_OVR]) |-> $stable(dpRxBuf));

  assert_irq_needs_enable_R9: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (ienReg != '0));

  assert_busy_needs_enable_R10: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> modEn);

  assert_disable_clears_R11: assert property (@(posedge clk) disable iff (!rstN)
    !modEn |=> (flags == '0 && !irq));

endmodule

bind serial_slave_dbuf ssd_checker #(.DATA_W(DATA_W)) u_checker (
  .clk(clk),
  .rstN(rstN),
  .regAddr(regAddr),
  .regRd(regRd),
  .modEn(modEn),
  .busy(busy),
  .irq(irq),
  .ienReg(ienReg),
  .flags(flags),
  .dpRxBuf(dpRxBuf),
  .ctl(ctl)
);

// File: tb/serial_slave_dbuf_bench.sv
module serial_slave_dbuf_bench;

  localparam int CLK_PERIOD = 10;
  localparam int HALF = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  regAddr = '0;
  logic        regWr = 1'b0;
  logic        regRd = 1'b0;
  logic [15:0] regWdata = '0;
  logic [15:0] regRdata;
  logic        irq;
  logic        sclk = 1'b0;
  logic        csN = 1'b1;
  logic        mosi = 1'b0;
  logic        miso;

  int checks = 0;
  int errors = 0;
  int curLen = 8;
  bit done = 1'b0;
  logic [15:0] expQ[$];

  serial_slave_dbuf u_serial_slave_dbuf (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr), .regRd(regRd),
    .regWdata(regWdata), .regRdata(regRdata), .irq(irq),
    .sclk(sclk), .csN(csN), .mosi(mosi), .miso(miso)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    regAddr = a; regWdata = d; regWr = 1'b1;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic regRead(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    regAddr = a; regRd = 1'b1;
    #1 d = regRdata;
    @(negedge clk);
    regRd = 1'b0;
  endtask

  task automatic expectReg(input string req, input logic [2:0] a, input logic [15:0] exp);
    logic [15:0] v;
    regRead(a, v);
    check(req, v, exp);
  endtask

  task automatic csAssert();
    @(negedge clk); csN = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic csRelease();
    repeat (4) @(negedge clk);
    csN = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic shiftBits(input int n, input logic [15:0] d);
    for (int i = n - 1; i >= 0; i--) begin
      mosi = d[i];
      repeat (HALF) @(negedge clk);
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (2) @(negedge clk);
  endtask

  // driver: pushes the expected output word, then clocks the character
  task automatic shiftChar(input logic [15:0] rxVal, input logic [15:0] expMiso);
    expQ.push_back(expMiso);
    shiftBits(curLen, rxVal);
  endtask

  // monitor: assembles output bits and compares full characters
  int monCnt = 0;
  logic [15:0] monAcc = '0;
  always @(posedge sclk or posedge csN) begin
    if (csN) begin
      monCnt = 0;
      monAcc = '0;
    end else begin
      monAcc = {monAcc[14:0], miso};
      monCnt++;
      if (monCnt == curLen) begin
        if (expQ.size() == 0) begin
          check("R3 unexpected output character", monAcc, 16'hxxxx);
        end else begin
          logic [15:0] e;
          e = expQ.pop_front();
          check("R3/R8 serial output word", monAcc, e & 16'((32'd1 << curLen) - 1));
        end
        monCnt = 0;
        monAcc = '0;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R1 reset state
    expectReg("R1 flags after reset", 3'd3, 16'h0000);
    check("R1 irq after reset", {15'd0, irq}, 16'd0);
    check("R1 miso after reset", {15'd0, miso}, 16'd0);

    // R2 R3 R4 R5 R6: basic 8-bit character
    curLen = 8;
    regWrite(3'd0, 16'h0071);
    expectReg("R2 control readback", 3'd0, 16'h0071);
    regWrite(3'd1, 16'h00A5);
    expectReg("R4 tbe low after tx write", 3'd3, 16'h0000);
    csAssert();
    shiftChar(16'h003C, 16'h00A5);
    csRelease();
    expectReg("R6 flags after sent char", 3'd3, 16'h0007);
    expectReg("R2 received data", 3'd2, 16'h003C);
    expectReg("R5 rbf cleared by rx read", 3'd3, 16'h0005);
    regWrite(3'd3, 16'h0003);
    expectReg("R4 write-one does not clear tbe or rbf", 3'd3, 16'h0005);
    regWrite(3'd3, 16'h0004);
    expectReg("R6 tend write-one clear", 3'd3, 16'h0001);

    // R7 R8 overrun with empty transmit buffer
    csAssert();
    shiftChar(16'h0011, 16'h0000);
    shiftChar(16'h0022, 16'h0000);
    csRelease();
    expectReg("R7 R8 flags after overrun, no tend", 3'd3, 16'h000B);
    expectReg("R7 old character kept", 3'd2, 16'h0011);
    regWrite(3'd3, 16'h0008);
    expectReg("R7 overrun write-one clear", 3'd3, 16'h0001);

    // R2 16-bit length
    curLen = 16;
    regWrite(3'd0, 16'h00F1);
    regWrite(3'd1, 16'hBEEF);
    csAssert();
    shiftChar(16'h1234, 16'hBEEF);
    csRelease();
    expectReg("R2 16-bit receive", 3'd2, 16'h1234);
    regWrite(3'd3, 16'h0004);

    // R2 1-bit length, upper tx bits ignored
    curLen = 1;
    regWrite(3'd0, 16'h0001);
    regWrite(3'd1, 16'hFFFF);
    csAssert();
    shiftChar(16'h0001, 16'h0001);
    csRelease();
    expectReg("R2 1-bit flags", 3'd3, 16'h0007);
    expectReg("R2 1-bit receive", 3'd2, 16'h0001);
    regWrite(3'd3, 16'h0004);

    // R6 R10 back-to-back characters with reload
    curLen = 8;
    regWrite(3'd0, 16'h0071);
    regWrite(3'd1, 16'h00A1);
    csAssert();
    regWrite(3'd1, 16'h00B2);
    shiftChar(16'h0055, 16'h00A1);
    expectReg("R6 R10 no tend while next queued, busy set", 3'd3, 16'h0013);
    expectReg("R5 first of pair", 3'd2, 16'h0055);
    shiftChar(16'h0066, 16'h00B2);
    csRelease();
    expectReg("R6 tend after last queued char", 3'd3, 16'h0007);
    expectReg("R5 second of pair", 3'd2, 16'h0066);

    // R9 interrupt masking
    regWrite(3'd4, 16'h0002);
    check("R9 irq masked for tend/tbe", {15'd0, irq}, 16'd0);
    regWrite(3'd4, 16'h0004);
    check("R9 irq from enabled tend", {15'd0, irq}, 16'd1);
    regWrite(3'd3, 16'h0004);
    check("R9 irq drops after tend clear", {15'd0, irq}, 16'd0);
    regWrite(3'd4, 16'h0001);
    check("R9 irq from tbe", {15'd0, irq}, 16'd1);
    regWrite(3'd4, 16'h0000);

    // R12 aborted partial character
    csAssert();
    shiftBits(3, 16'h0007);
    csRelease();
    expectReg("R12 partial character leaves flags", 3'd3, 16'h0001);
    regWrite(3'd1, 16'h003C);
    csAssert();
    shiftChar(16'h00C3, 16'h003C);
    csRelease();
    expectReg("R12 fresh character after abort", 3'd2, 16'h00C3);
    regWrite(3'd3, 16'h0004);

    // R11 disable wipes state, ignores serial activity
    csAssert();
    shiftChar(16'h0042, 16'h0000);
    csRelease();
    expectReg("R11 flags before disable", 3'd3, 16'h0003);
    regWrite(3'd4, 16'h000F);
    regWrite(3'd0, 16'h0070);
    expectReg("R11 flags cleared by disable", 3'd3, 16'h0000);
    check("R11 irq low while disabled", {15'd0, irq}, 16'd0);
    regWrite(3'd1, 16'h00FF);
    csAssert();
    expectReg("R10 busy stays low while disabled", 3'd3, 16'h0000);
    shiftChar(16'h0099, 16'h0000);
    csRelease();
    regWrite(3'd0, 16'h0071);
    expectReg("R11 no flags from disabled traffic", 3'd3, 16'h0000);
    expectReg("R11 receive buffer wiped", 3'd2, 16'h0000);
    regWrite(3'd4, 16'h0000);

    check("R3 all expected characters seen", 16'(expQ.size()), 16'd0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule